// File: doc/BRIEF.md
# Non-Volatile Memory Protection Gate

This block decides, for every request, whether a chip-wide erase or a write to the configuration area may go ahead. It works from three protection bits held in the configuration area: secure-access protect, access protect and erase protect. It copies these bits once, in the first cycle after reset is released. Values written to the configuration area later only take effect after the next reset. The block judges two independent erase paths. The first is a software erase-all, which also needs erase mode to be active and which answers a refusal with a bus error. The second is an erase-all from the debug control port, which only erase protect can stop.

The block also gates configuration-area writes by the security attribute of the transaction. It decodes a keyed, non-secure protection-set register. A valid keyed write makes the block request that the access-protect word be programmed to all zeroes.

The flash timing is outside the block. Its outputs are single-cycle pulses that the flash sequencer consumes. Every output is registered, so the result for a request sampled at clock edge k appears after edge k and stays for exactly one cycle.

The capture machine has two states. `ST_SAMPLE` is the reset state. On the first edge after reset it copies the protection bits and takes the transition *capture* to `ST_OPEN`. `ST_OPEN` holds until the next reset. Requests sampled while the machine is in `ST_SAMPLE` are refused.

Top module: `nvm_prot_gate`

## Requirements
- R1: With all three latched protection bits at 0, a software erase-all issued while erase mode is active is granted, and a debug-port erase-all is granted.
- R2: With erase protect at 0 and secure-access protect or access protect at 1, a software erase-all gets a bus error instead of a grant, while a debug-port erase-all is still granted.
- R3: With erase protect at 1, a software erase-all gets a bus error and a debug-port erase-all is denied, whatever the other two bits are.
- R4: A software erase-all issued without erase mode active gets a bus error and no grant, whatever the protection bits are.
- R5: A configuration-area write from a non-secure transaction (secure flag 0) is faulted. A write from a secure transaction (secure flag 1) is granted once the capture is done.
- R6: The protection bits are copied only on the first edge after reset. Later changes on the protection inputs change no decision. Every request sampled on that capture edge is refused: error, deny or fault, and no program request.
- R7: A keyed write whose bits 31:4 equal 0xAFBE5A7 and whose bit 0 is 1 produces a one-cycle access-protect program request, with program data 0x00000000.
- R8: A keyed write with any other value in bits 31:4, or with bit 0 at 0, produces no program request.
- R9: Each request produces exactly one outcome pulse (grant or refusal), one cycle after it is sampled. With no request, every output is 0. After reset, ready is 0 and every output is 0.
- R10: The software and debug-port erase requests are judged independently when they arrive in the same cycle. Each gets its own outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sec_ap_i | input | 1 | Secure-access protect bit read from the configuration area |
| cfg_ap_i | input | 1 | Access protect bit read from the configuration area |
| cfg_erase_prot_i | input | 1 | Erase protect bit read from the configuration area |
| sw_erase_req_i | input | 1 | Software erase-all request |
| erase_mode_i | input | 1 | Erase mode is active |
| dbg_erase_req_i | input | 1 | Debug control port erase-all request |
| cfg_wr_req_i | input | 1 | Configuration-area write request |
| cfg_wr_secure_i | input | 1 | Security attribute of that write (1 = secure) |
| key_wr_i | input | 1 | Write strobe of the keyed protection-set register |
| key_wdata_i | input | 32 | Data of the keyed write |
| prot_ready_o | output | 1 | Protection bits captured |
| sw_erase_grant_o | output | 1 | Software erase-all granted |
| sw_erase_err_o | output | 1 | Software erase-all refused with bus error |
| dbg_erase_grant_o | output | 1 | Debug-port erase-all granted |
| dbg_erase_deny_o | output | 1 | Debug-port erase-all denied |
| cfg_wr_grant_o | output | 1 | Configuration-area write granted |
| cfg_wr_fault_o | output | 1 | Configuration-area write faulted |
| ap_prog_req_o | output | 1 | Request to program the access-protect word |
| ap_prog_data_o | output | 32 | Value to program into the access-protect word |

## Verification
Both erase paths can be requested in the same cycle, and they have to be judged separately. The bench drives every combination of the software request, the debug request, erase mode, the configuration write and its secure flag. It does this under all eight latched protection patterns, so the two erase requests often fall in one cycle. The bench works out each path's outcome from the protection table and compares the two outcome pairs separately, one cycle after the request. A correct design must not let a refusal on one path leak into the other.

// File: rtl/nvm_prot_pkg.sv
package nvm_prot_pkg;

    typedef enum logic [0:0] {
        ST_SAMPLE = 1'b0,
        ST_OPEN   = 1'b1
    } cap_state_t;

    typedef struct packed {
        logic sec_ap;
        logic ap;
        logic erase_prot;
    } prot_bits_t;

    localparam int unsigned KEY_W   = 28;
    localparam logic [KEY_W-1:0] SET_KEY = 28'hAFBE5A7;

endpackage

// File: rtl/nvm_prot_capture.sv
module nvm_prot_capture
    import nvm_prot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  prot_bits_t raw_i,
    output prot_bits_t prot_o,
    output logic       ready_o
);

    cap_state_t state_q, state_d;
    prot_bits_t prot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SAMPLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SAMPLE: state_d = ST_OPEN;
            ST_OPEN:   state_d = ST_OPEN;
            default:   state_d = ST_SAMPLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_q <= '0;
        end else if (state_q == ST_SAMPLE) begin
            prot_q <= raw_i;
        end
    end

    always_comb begin
        prot_o  = prot_q;
        ready_o = (state_q == ST_OPEN);
    end

    AST_BITS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && $past(ready_o)) |-> $stable(prot_q)); // R6

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ready_o) |-> ready_o); // R6

endmodule

// File: rtl/nvm_erase_arbiter.sv
module nvm_erase_arbiter
    import nvm_prot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ready_i,
    input  prot_bits_t prot_i,
    input  logic       sw_req_i,
    input  logic       erase_mode_i,
    input  logic       dbg_req_i,
    output logic       sw_grant_o,
    output logic       sw_err_o,
    output logic       dbg_grant_o,
    output logic       dbg_deny_o
);

    logic sw_ok;
    logic dbg_ok;

    always_comb begin
        sw_ok  = ready_i && erase_mode_i
                 && !(prot_i.sec_ap || prot_i.ap || prot_i.erase_prot);
        dbg_ok = ready_i && !prot_i.erase_prot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_grant_o  <= 1'b0;
            sw_err_o    <= 1'b0;
            dbg_grant_o <= 1'b0;
            dbg_deny_o  <= 1'b0;
        end else begin
            sw_grant_o  <= sw_req_i  &&  sw_ok;
            sw_err_o    <= sw_req_i  && !sw_ok;
            dbg_grant_o <= dbg_req_i &&  dbg_ok;
            dbg_deny_o  <= dbg_req_i && !dbg_ok;
        end
    end

    AST_SW_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sw_grant_o |-> !(prot_i.sec_ap || prot_i.ap || prot_i.erase_prot)); // R2

    AST_EP_BLOCKS_DBG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dbg_req_i) && prot_i.erase_prot) |-> !dbg_grant_o); // R3

    AST_SW_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_grant_o |-> $past(erase_mode_i)); // R4

    AST_SW_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_req_i) |-> (sw_grant_o != sw_err_o)); // R9

    AST_SW_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sw_req_i) |-> !(sw_grant_o || sw_err_o)); // R9

    AST_DBG_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dbg_req_i) |-> (dbg_grant_o != dbg_deny_o)); // R10

endmodule

// File: rtl/nvm_cfg_write_gate.sv
module nvm_cfg_write_gate
    import nvm_prot_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready_i,
    input  logic              cfg_req_i,
    input  logic              cfg_secure_i,
    input  logic              key_wr_i,
    input  logic [DATA_W-1:0] key_wdata_i,
    output logic              cfg_grant_o,
    output logic              cfg_fault_o,
    output logic              ap_req_o,
    output logic [DATA_W-1:0] ap_data_o
);

    localparam int unsigned KEY_LSB = DATA_W - KEY_W;

    logic key_match;
    logic cfg_ok;
    logic key_unused;

    always_comb begin
        key_match  = (key_wdata_i[DATA_W-1:KEY_LSB] == SET_KEY) && key_wdata_i[0];
        cfg_ok     = ready_i && cfg_secure_i;
        key_unused = ^key_wdata_i[KEY_LSB-1:1];
        ap_data_o  = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_grant_o <= 1'b0;
            cfg_fault_o <= 1'b0;
            ap_req_o    <= 1'b0;
        end else begin
            cfg_grant_o <= cfg_req_i &&  cfg_ok;
            cfg_fault_o <= cfg_req_i && !cfg_ok;
            ap_req_o    <= key_wr_i && ready_i && key_match;
        end
    end

    AST_NS_WRITE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_req_i && !cfg_secure_i) |-> (cfg_fault_o && !cfg_grant_o)); // R5

    AST_KEY_REQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req_o |-> ($past(key_wr_i) && $past(key_wdata_i[0]))); // R7

    AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(key_wr_i) && ($past(key_wdata_i[DATA_W-1:KEY_LSB]) != SET_KEY))
        |-> !ap_req_o); // R8

    AST_AP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(key_wr_i) |-> !ap_req_o); // R9

endmodule

// File: rtl/nvm_prot_gate.sv
module nvm_prot_gate
    import nvm_prot_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sec_ap_i,
    input  logic              cfg_ap_i,
    input  logic              cfg_erase_prot_i,
    input  logic              sw_erase_req_i,
    input  logic              erase_mode_i,
    input  logic              dbg_erase_req_i,
    input  logic              cfg_wr_req_i,
    input  logic              cfg_wr_secure_i,
    input  logic              key_wr_i,
    input  logic [DATA_W-1:0] key_wdata_i,
    output logic              prot_ready_o,
    output logic              sw_erase_grant_o,
    output logic              sw_erase_err_o,
    output logic              dbg_erase_grant_o,
    output logic              dbg_erase_deny_o,
    output logic              cfg_wr_grant_o,
    output logic              cfg_wr_fault_o,
    output logic              ap_prog_req_o,
    output logic [DATA_W-1:0] ap_prog_data_o
);

    prot_bits_t raw_bits;
    prot_bits_t prot_bits;
    logic       ready;

    always_comb begin
        raw_bits.sec_ap     = cfg_sec_ap_i;
        raw_bits.ap         = cfg_ap_i;
        raw_bits.erase_prot = cfg_erase_prot_i;
        prot_ready_o        = ready;
    end

    nvm_prot_capture u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (raw_bits),
        .prot_o  (prot_bits),
        .ready_o (ready)
    );

    nvm_erase_arbiter u_erase (
        .clk          (clk),
        .rst_n        (rst_n),
        .ready_i      (ready),
        .prot_i       (prot_bits),
        .sw_req_i     (sw_erase_req_i),
        .erase_mode_i (erase_mode_i),
        .dbg_req_i    (dbg_erase_req_i),
        .sw_grant_o   (sw_erase_grant_o),
        .sw_err_o     (sw_erase_err_o),
        .dbg_grant_o  (dbg_erase_grant_o),
        .dbg_deny_o   (dbg_erase_deny_o)
    );

    nvm_cfg_write_gate #(.DATA_W(DATA_W)) u_cfgwr (
        .clk          (clk),
        .rst_n        (rst_n),
        .ready_i      (ready),
        .cfg_req_i    (cfg_wr_req_i),
        .cfg_secure_i (cfg_wr_secure_i),
        .key_wr_i     (key_wr_i),
        .key_wdata_i  (key_wdata_i),
        .cfg_grant_o  (cfg_wr_grant_o),
        .cfg_fault_o  (cfg_wr_fault_o),
        .ap_req_o     (ap_prog_req_o),
        .ap_data_o    (ap_prog_data_o)
    );

    AST_NO_GRANT_BEFORE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ready) |-> !(sw_erase_grant_o || dbg_erase_grant_o
                            || cfg_wr_grant_o || ap_prog_req_o)); // R6

endmodule

// File: tb/tb_nvm_prot_gate.sv
module tb_nvm_prot_gate;

    localparam logic [31:0] GOOD_KEY = 32'hAFBE5A71;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sap = 1'b0, ap = 1'b0, ep = 1'b0;
    logic        sw_req = 1'b0, em = 1'b0, dbg_req = 1'b0;
    logic        cw_req = 1'b0, cw_sec = 1'b0, kw = 1'b0;
    logic [31:0] kd = '0;
    logic        ready, sw_g, sw_e, dbg_g, dbg_d, cw_g, cw_f, ap_req;
    logic [31:0] ap_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    nvm_prot_gate dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_sec_ap_i(sap), .cfg_ap_i(ap), .cfg_erase_prot_i(ep),
        .sw_erase_req_i(sw_req), .erase_mode_i(em), .dbg_erase_req_i(dbg_req),
        .cfg_wr_req_i(cw_req), .cfg_wr_secure_i(cw_sec),
        .key_wr_i(kw), .key_wdata_i(kd),
        .prot_ready_o(ready),
        .sw_erase_grant_o(sw_g), .sw_erase_err_o(sw_e),
        .dbg_erase_grant_o(dbg_g), .dbg_erase_deny_o(dbg_d),
        .cfg_wr_grant_o(cw_g), .cfg_wr_fault_o(cw_f),
        .ap_prog_req_o(ap_req), .ap_prog_data_o(ap_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sw_req = 0; em = 0; dbg_req = 0; cw_req = 0; cw_sec = 0; kw = 0; kd = '0;
    endtask

    task automatic check_quiet(input string tag);
        chk(tag, {sw_g, sw_e, dbg_g, dbg_d, cw_g, cw_f, ap_req}, 7'b0);
    endtask

    // drive at a negedge, sample one cycle later, then confirm the pulse ends
    task automatic apply(input logic [2:0] pb, input logic s, input logic m,
                         input logic d, input logic c, input logic sec,
                         input logic k, input logic [31:0] kdat, input logic rdy);
        logic sw_ok, dbg_ok, cw_ok, ap_ok;
        string etag;
        sw_req = s; em = m; dbg_req = d; cw_req = c; cw_sec = sec; kw = k; kd = kdat;
        @(negedge clk);
        sw_ok  = rdy && m && (pb == 3'b000);
        dbg_ok = rdy && !pb[0];
        cw_ok  = rdy && sec;
        ap_ok  = rdy && k && (kdat[31:4] == 28'hAFBE5A7) && kdat[0];
        if (!rdy)                 etag = "R6 refuse before capture";
        else if (pb[0])           etag = "R3 erase protect";
        else if (pb != 3'b000)    etag = "R2 access protect";
        else if (!m)              etag = "R4 no erase mode";
        else                      etag = "R1 unprotected";
        chk({etag, " sw path"}, {sw_g, sw_e}, {s && sw_ok, s && !sw_ok});
        chk({etag, " R10 dbg path"}, {dbg_g, dbg_d}, {d && dbg_ok, d && !dbg_ok});
        chk("R5 cfg write", {cw_g, cw_f}, {c && cw_ok, c && !cw_ok});
        chk(ap_ok ? "R7 keyed set" : "R8 keyed ignore", {ap_req, ap_data},
            {ap_ok, 32'h0});
        idle_inputs();
        @(negedge clk);
        check_quiet("R9 pulse ends");
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 8; c++) begin
            logic [2:0] pb;
            pb = c[2:0];
            rst_n = 0;
            idle_inputs();
            {sap, ap, ep} = pb;
            repeat (2) @(negedge clk);
            chk("R9 reset state", {ready, sw_g, sw_e, dbg_g, dbg_d, cw_g, cw_f, ap_req},
                8'b0);
            rst_n = 1;
            if (c == 0) begin
                // every request lands on the capture edge and must be refused
                apply(pb, 1, 1, 1, 1, 1, 1, GOOD_KEY, 1'b0);
                chk("R6 ready after capture", {63'b0, ready}, 64'd1);
            end else begin
                @(negedge clk);
                chk("R6 ready after capture", {63'b0, ready}, 64'd1);
            end
            // later changes on the protection inputs must be ignored
            {sap, ap, ep} = ~pb;
            for (int v = 0; v < 32; v++) begin
                logic [4:0] b;
                b = v[4:0];
                apply(pb, b[0], b[1], b[2], b[3], b[4], 0, '0, 1'b1);
            end
            apply(pb, 0, 0, 0, 0, 0, 1, GOOD_KEY, 1'b1);
            apply(pb, 0, 0, 0, 0, 0, 1, GOOD_KEY ^ (32'h1 << (4 + c)), 1'b1);
            apply(pb, 0, 0, 0, 0, 0, 1, GOOD_KEY & ~32'h1, 1'b1);
            apply(pb, 1, 1, 1, 0, 0, 1, GOOD_KEY, 1'b1);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule